// File: doc/BRIEF.md
# Circular Segment Page Allocator

This block hands out physical flash pages for a store that is split into equal segments. A table of per-segment state is kept in on-chip registers. For each segment it records whether the segment is owned, whether it is the first segment of its file, a link to the following segment of the same file, the offset of the next page to write, and a wear count. A file is named by the index of its first segment. The first page of a segment is its index times the page count, so it is derived and not stored.

A client issues one request at a time over a valid/ready handshake and gets back a one-cycle grant. There are four requests. Create opens a new file on the least-worn free segment. Append returns the next page to write in the last segment of a file. Pages in a segment are used round-robin, and the segment's wear count rises each time its pointer wraps. Extend chains one more least-worn free segment onto the end of a file. Free walks the chain of a file and releases every segment in it, keeping the wear counts. When no free segment exists, or when a handle does not name an owned first segment, the grant carries an error flag and the table is left unchanged.

Top module: `seg_page_alloc`

## Requirements
- R1: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The `req_op` encoding is 0 create, 1 append, 2 extend and 3 free. Each accepted request produces exactly one cycle of `gnt_valid`. `req_ready` is low from acceptance until the grant and is high in the cycle the grant is visible.
- R2: After reset every segment is free and every wear count is zero, `req_ready` is high and `gnt_valid` is low.
- R3: Create takes the free segment with the lowest wear count, with ties going to the lowest index. It grants with `gnt_file` set to that index, `gnt_page` set to index times 32 and `gnt_wear` set to its current count.
- R4: Append grants `gnt_page` = segment × 32 + offset, where the segment is the last one in the file's chain. The offsets of a segment run 0, 1, …, 31 and then wrap to 0. A newly assigned segment starts at offset 0, and `gnt_file` echoes the handle.
- R5: An append at offset 31 adds one to that segment's wear count. `gnt_wear` on an append reports the count after that write. The count saturates at 255.
- R6: Extend links the least-worn free segment (ties to the lowest index) behind the file's last segment. It grants that segment's index, its first page and its count. Later appends to the file use the new segment.
- R7: Free releases every segment of the file's chain while keeping their wear counts. It grants `gnt_file` = handle, page 0 and wear 0.
- R8: A create or extend with no free segment grants `gnt_err` = 1, with file, page and wear 0 for create and file = handle for extend. The table is left unchanged.
- R9: An append, extend or free whose handle is not the first segment of an owned file grants `gnt_err` = 1 with `gnt_file` = handle and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Request kind: 0 create, 1 append, 2 extend, 3 free |
| req_file | input | 6 | File handle (index of the file's first segment) |
| req_ready | output | 1 | Block idle and able to take a request |
| gnt_valid | output | 1 | One-cycle grant for the accepted request |
| gnt_err | output | 1 | Request refused |
| gnt_file | output | 6 | Handle or segment index of the grant |
| gnt_page | output | 11 | Physical page number |
| gnt_wear | output | 8 | Wear count of the segment named by the grant |

## Verification
A wrong write pointer shows up on the very next append to that file as a page offset out of sequence. A wrong wear count stays hidden until the 32nd append to that segment, or until a later create or extend picks a different segment than the lowest-count rule predicts. A broken chain link or a lost free mark appears at the next append, extend or free on that file: the page lands in the wrong segment, or an error or grant comes back that the request history does not justify. Leaked or double-owned segments only surface once the free pool runs dry, so the pool is drained to exhaustion and refilled, and the wear counter is driven to saturation.

// File: rtl/spa_pkg.sv
package spa_pkg;

  typedef enum logic [1:0] {
    OP_CREATE = 2'd0,
    OP_APPEND = 2'd1,
    OP_EXTEND = 2'd2,
    OP_FREE   = 2'd3
  } spa_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CREATE = 2'd1,
    ST_WALK   = 2'd2
  } spa_state_e;

endpackage

// File: rtl/spa_min_pick.sv
// Balanced reduction tree: finds the free segment with the smallest wear
// count, preferring the lower index on equal counts.
module spa_min_pick #(
  parameter int NSEG  = 64,
  parameter int CNT_W = 8,
  localparam int SEG_W = $clog2(NSEG)
) (
  input  logic [NSEG-1:0]  free_mask,
  input  logic [CNT_W-1:0] cnt_all [NSEG],
  output logic             found,
  output logic [SEG_W-1:0] pick_seg,
  output logic [CNT_W-1:0] pick_cnt
);

  for (genvar l = SEG_W; l >= 0; l--) begin : g_lvl
    localparam int NN = 1 << l;
    logic             v  [NN];
    logic [SEG_W-1:0] ix [NN];
    logic [CNT_W-1:0] c  [NN];

    if (l == SEG_W) begin : g_leaf
      for (genvar k = 0; k < NN; k++) begin : g_k
        assign v[k]  = free_mask[k];
        assign ix[k] = SEG_W'(k);
        assign c[k]  = cnt_all[k];
      end
    end else begin : g_node
      for (genvar k = 0; k < NN; k++) begin : g_k
        logic take_hi;
        assign take_hi = g_lvl[l+1].v[2*k+1] &&
                         (!g_lvl[l+1].v[2*k] ||
                          (g_lvl[l+1].c[2*k+1] < g_lvl[l+1].c[2*k]));
        assign v[k]  = g_lvl[l+1].v[2*k] || g_lvl[l+1].v[2*k+1];
        assign ix[k] = take_hi ? g_lvl[l+1].ix[2*k+1] : g_lvl[l+1].ix[2*k];
        assign c[k]  = take_hi ? g_lvl[l+1].c[2*k+1]  : g_lvl[l+1].c[2*k];
      end
    end
  end

  assign found    = g_lvl[0].v[0];
  assign pick_seg = g_lvl[0].ix[0];
  assign pick_cnt = g_lvl[0].c[0];

endmodule

// File: rtl/spa_seg_table.sv
// Per-segment state registers with one read port and four write commands.
module spa_seg_table #(
  parameter int NSEG  = 64,
  parameter int NPAGE = 32,
  parameter int CNT_W = 8,
  localparam int SEG_W  = $clog2(NSEG),
  localparam int PAGE_W = $clog2(NPAGE),
  localparam int LINK_W = SEG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [SEG_W-1:0]  alloc_seg,
  input  logic              alloc_head,
  input  logic              link_en,
  input  logic [SEG_W-1:0]  link_seg,
  input  logic [LINK_W-1:0] link_tgt,
  input  logic              bump_en,
  input  logic [SEG_W-1:0]  bump_seg,
  input  logic              rel_en,
  input  logic [SEG_W-1:0]  rel_seg,
  input  logic [SEG_W-1:0]  rd_seg,
  output logic              rd_used,
  output logic              rd_head,
  output logic [LINK_W-1:0] rd_next,
  output logic [PAGE_W-1:0] rd_ptr,
  output logic [CNT_W-1:0]  rd_cnt_wr,
  output logic [NSEG-1:0]   free_mask,
  output logic [CNT_W-1:0]  cnt_all [NSEG]
);

  localparam logic [LINK_W-1:0] LINK_NONE = '1;
  localparam logic [PAGE_W-1:0] PTR_LAST  = PAGE_W'(NPAGE - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

  logic              used_q [NSEG];
  logic              head_q [NSEG];
  logic [LINK_W-1:0] next_q [NSEG];
  logic [PAGE_W-1:0] ptr_q  [NSEG];
  logic [CNT_W-1:0]  cnt_q  [NSEG];

  for (genvar s = 0; s < NSEG; s++) begin : g_ent
    logic              hit_alloc, hit_link, hit_bump, hit_rel, ent_we;
    logic              used_d, head_d;
    logic [LINK_W-1:0] next_d;
    logic [PAGE_W-1:0] ptr_d;
    logic [CNT_W-1:0]  cnt_d;

    assign hit_alloc = alloc_en && (alloc_seg == SEG_W'(s));
    assign hit_link  = link_en  && (link_seg  == SEG_W'(s));
    assign hit_bump  = bump_en  && (bump_seg  == SEG_W'(s));
    assign hit_rel   = rel_en   && (rel_seg   == SEG_W'(s));
    assign ent_we    = hit_alloc || hit_link || hit_bump || hit_rel;

    always_comb begin
      used_d = used_q[s];
      head_d = head_q[s];
      next_d = next_q[s];
      ptr_d  = ptr_q[s];
      cnt_d  = cnt_q[s];
      if (hit_rel) begin
        used_d = 1'b0;
        head_d = 1'b0;
        next_d = LINK_NONE;
      end
      if (hit_alloc) begin
        used_d = 1'b1;
        head_d = alloc_head;
        next_d = LINK_NONE;
        ptr_d  = '0;
      end
      if (hit_link) begin
        next_d = link_tgt;
      end
      if (hit_bump) begin
        if (ptr_q[s] == PTR_LAST) begin
          ptr_d = '0;
          if (cnt_q[s] != CNT_MAX) cnt_d = cnt_q[s] + 1'b1;
        end else begin
          ptr_d = ptr_q[s] + 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        used_q[s] <= 1'b0;
        head_q[s] <= 1'b0;
        next_q[s] <= LINK_NONE;
        ptr_q[s]  <= '0;
        cnt_q[s]  <= '0;
      end else if (ent_we) begin
        used_q[s] <= used_d;
        head_q[s] <= head_d;
        next_q[s] <= next_d;
        ptr_q[s]  <= ptr_d;
        cnt_q[s]  <= cnt_d;
      end
    end

    assign free_mask[s] = !used_q[s];
    assign cnt_all[s]   = cnt_q[s];
  end

  assign rd_used = used_q[rd_seg];
  assign rd_head = head_q[rd_seg];
  assign rd_next = next_q[rd_seg];
  assign rd_ptr  = ptr_q[rd_seg];

  // Count that results from writing the page at rd_ptr.
  always_comb begin
    rd_cnt_wr = cnt_q[rd_seg];
    if ((ptr_q[rd_seg] == PTR_LAST) && (cnt_q[rd_seg] != CNT_MAX))
      rd_cnt_wr = cnt_q[rd_seg] + 1'b1;
  end

endmodule

// File: rtl/spa_ctrl.sv
// Request sequencer: accepts one request, walks a file chain one segment
// per cycle, issues table writes and a registered one-cycle grant.
module spa_ctrl
  import spa_pkg::*;
#(
  parameter int NSEG  = 64,
  parameter int NPAGE = 32,
  parameter int CNT_W = 8,
  localparam int SEG_W  = $clog2(NSEG),
  localparam int PAGE_W = $clog2(NPAGE),
  localparam int LINK_W = SEG_W + 1,
  localparam int ADDR_W = SEG_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [SEG_W-1:0]  req_file,
  output logic              req_ready,
  output logic              gnt_valid,
  output logic              gnt_err,
  output logic [SEG_W-1:0]  gnt_file,
  output logic [ADDR_W-1:0] gnt_page,
  output logic [CNT_W-1:0]  gnt_wear,
  output logic [SEG_W-1:0]  rd_seg,
  input  logic              rd_used,
  input  logic              rd_head,
  input  logic [LINK_W-1:0] rd_next,
  input  logic [PAGE_W-1:0] rd_ptr,
  input  logic [CNT_W-1:0]  rd_cnt_wr,
  input  logic              pick_found,
  input  logic [SEG_W-1:0]  pick_seg,
  input  logic [CNT_W-1:0]  pick_cnt,
  output logic              alloc_en,
  output logic [SEG_W-1:0]  alloc_seg,
  output logic              alloc_head,
  output logic              link_en,
  output logic [SEG_W-1:0]  link_seg,
  output logic [LINK_W-1:0] link_tgt,
  output logic              bump_en,
  output logic [SEG_W-1:0]  bump_seg,
  output logic              rel_en,
  output logic [SEG_W-1:0]  rel_seg
);

  localparam logic [LINK_W-1:0] LINK_NONE = '1;

  spa_state_e        state_q, state_d;
  spa_op_e           op_q, op_d;
  logic [SEG_W-1:0]  file_q, file_d;
  logic [SEG_W-1:0]  cur_q, cur_d;
  logic              gv_q, gv_d, ge_q, ge_d;
  logic [SEG_W-1:0]  gf_q, gf_d;
  logic [ADDR_W-1:0] gp_q, gp_d;
  logic [CNT_W-1:0]  gw_q, gw_d;
  logic              at_tail;

  assign rd_seg  = (state_q == ST_IDLE) ? req_file : cur_q;
  assign at_tail = (rd_next == LINK_NONE);

  always_comb begin
    state_d    = state_q;
    op_d       = op_q;
    file_d     = file_q;
    cur_d      = cur_q;
    gv_d       = 1'b0;
    ge_d       = 1'b0;
    gf_d       = gf_q;
    gp_d       = gp_q;
    gw_d       = gw_q;
    alloc_en   = 1'b0;
    alloc_seg  = pick_seg;
    alloc_head = 1'b0;
    link_en    = 1'b0;
    link_seg   = cur_q;
    link_tgt   = LINK_W'(pick_seg);
    bump_en    = 1'b0;
    bump_seg   = cur_q;
    rel_en     = 1'b0;
    rel_seg    = cur_q;

    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          op_d   = spa_op_e'(req_op);
          file_d = req_file;
          cur_d  = req_file;
          if (spa_op_e'(req_op) == OP_CREATE) begin
            state_d = ST_CREATE;
          end else if (rd_used && rd_head) begin
            state_d = ST_WALK;
          end else begin
            gv_d = 1'b1; ge_d = 1'b1;
            gf_d = req_file; gp_d = '0; gw_d = '0;
          end
        end
      end

      ST_CREATE: begin
        state_d = ST_IDLE;
        gv_d    = 1'b1;
        if (pick_found) begin
          alloc_en   = 1'b1;
          alloc_head = 1'b1;
          gf_d = pick_seg; gp_d = {pick_seg, PAGE_W'(0)}; gw_d = pick_cnt;
        end else begin
          ge_d = 1'b1; gf_d = '0; gp_d = '0; gw_d = '0;
        end
      end

      ST_WALK: begin
        if (op_q == OP_FREE) begin
          rel_en = 1'b1;
          if (at_tail) begin
            state_d = ST_IDLE;
            gv_d = 1'b1; gf_d = file_q; gp_d = '0; gw_d = '0;
          end else begin
            cur_d = rd_next[SEG_W-1:0];
          end
        end else if (!at_tail) begin
          cur_d = rd_next[SEG_W-1:0];
        end else if (op_q == OP_APPEND) begin
          bump_en = 1'b1;
          state_d = ST_IDLE;
          gv_d = 1'b1; gf_d = file_q; gp_d = {cur_q, rd_ptr}; gw_d = rd_cnt_wr;
        end else begin
          state_d = ST_IDLE;
          gv_d    = 1'b1;
          if (pick_found) begin
            link_en  = 1'b1;
            alloc_en = 1'b1;
            gf_d = pick_seg; gp_d = {pick_seg, PAGE_W'(0)}; gw_d = pick_cnt;
          end else begin
            ge_d = 1'b1; gf_d = file_q; gp_d = '0; gw_d = '0;
          end
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_CREATE;
      file_q  <= '0;
      cur_q   <= '0;
      gv_q    <= 1'b0;
      ge_q    <= 1'b0;
      gf_q    <= '0;
      gp_q    <= '0;
      gw_q    <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      file_q  <= file_d;
      cur_q   <= cur_d;
      gv_q    <= gv_d;
      ge_q    <= ge_d;
      gf_q    <= gf_d;
      gp_q    <= gp_d;
      gw_q    <= gw_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign gnt_valid = gv_q;
  assign gnt_err   = ge_q;
  assign gnt_file  = gf_q;
  assign gnt_page  = gp_q;
  assign gnt_wear  = gw_q;

endmodule

// File: rtl/seg_page_alloc.sv
module seg_page_alloc #(
  parameter int NSEG  = 64,
  parameter int NPAGE = 32,
  parameter int CNT_W = 8,
  localparam int SEG_W  = $clog2(NSEG),
  localparam int PAGE_W = $clog2(NPAGE),
  localparam int LINK_W = SEG_W + 1,
  localparam int ADDR_W = SEG_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [SEG_W-1:0]  req_file,
  output logic              req_ready,
  output logic              gnt_valid,
  output logic              gnt_err,
  output logic [SEG_W-1:0]  gnt_file,
  output logic [ADDR_W-1:0] gnt_page,
  output logic [CNT_W-1:0]  gnt_wear
);

  // Reset: asserts at once, releases on the second clock edge.
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic [SEG_W-1:0]  rd_seg;
  logic              rd_used, rd_head;
  logic [LINK_W-1:0] rd_next;
  logic [PAGE_W-1:0] rd_ptr;
  logic [CNT_W-1:0]  rd_cnt_wr;
  logic [NSEG-1:0]   free_mask;
  logic [CNT_W-1:0]  cnt_all [NSEG];
  logic              pick_found;
  logic [SEG_W-1:0]  pick_seg;
  logic [CNT_W-1:0]  pick_cnt;
  logic              alloc_en, alloc_head, link_en, bump_en, rel_en;
  logic [SEG_W-1:0]  alloc_seg, link_seg, bump_seg, rel_seg;
  logic [LINK_W-1:0] link_tgt;

  spa_seg_table #(.NSEG(NSEG), .NPAGE(NPAGE), .CNT_W(CNT_W)) u_table (
    .clk(clk), .rst_n(rst_s),
    .alloc_en(alloc_en), .alloc_seg(alloc_seg), .alloc_head(alloc_head),
    .link_en(link_en), .link_seg(link_seg), .link_tgt(link_tgt),
    .bump_en(bump_en), .bump_seg(bump_seg),
    .rel_en(rel_en), .rel_seg(rel_seg),
    .rd_seg(rd_seg), .rd_used(rd_used), .rd_head(rd_head),
    .rd_next(rd_next), .rd_ptr(rd_ptr), .rd_cnt_wr(rd_cnt_wr),
    .free_mask(free_mask), .cnt_all(cnt_all)
  );

  spa_min_pick #(.NSEG(NSEG), .CNT_W(CNT_W)) u_pick (
    .free_mask(free_mask), .cnt_all(cnt_all),
    .found(pick_found), .pick_seg(pick_seg), .pick_cnt(pick_cnt)
  );

  spa_ctrl #(.NSEG(NSEG), .NPAGE(NPAGE), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_s),
    .req_valid(req_valid), .req_op(req_op), .req_file(req_file),
    .req_ready(req_ready),
    .gnt_valid(gnt_valid), .gnt_err(gnt_err), .gnt_file(gnt_file),
    .gnt_page(gnt_page), .gnt_wear(gnt_wear),
    .rd_seg(rd_seg), .rd_used(rd_used), .rd_head(rd_head),
    .rd_next(rd_next), .rd_ptr(rd_ptr), .rd_cnt_wr(rd_cnt_wr),
    .pick_found(pick_found), .pick_seg(pick_seg), .pick_cnt(pick_cnt),
    .alloc_en(alloc_en), .alloc_seg(alloc_seg), .alloc_head(alloc_head),
    .link_en(link_en), .link_seg(link_seg), .link_tgt(link_tgt),
    .bump_en(bump_en), .bump_seg(bump_seg),
    .rel_en(rel_en), .rel_seg(rel_seg)
  );

endmodule

// File: rtl/spa_checker.sv
module spa_checker #(
  parameter int NSEG = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_op,
  input logic            req_ready,
  input logic            gnt_valid,
  input logic            gnt_err,
  input logic [NSEG-1:0] free_mask
);

  logic [1:0] trk_op;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      trk_op <= 2'd0;
    else if (req_valid && req_ready) trk_op <= req_op;
  end

  // R1: the block is idle again when its grant is visible
  a_r1_ready_at_grant: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> req_ready);

  // R3: a successful create takes exactly one segment out of the pool
  a_r3_create_takes_one: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_err && trk_op == 2'd0) |->
      ($countones(free_mask) + 1 == $countones($past(free_mask))));

  // R4: an append never changes which segments are owned
  a_r4_append_keeps_pool: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_err && trk_op == 2'd1) |-> $stable(free_mask));

  // R7: a successful free returns segments to the pool
  a_r7_free_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_err && trk_op == 2'd3) |->
      ($countones(free_mask) > $countones($past(free_mask))));

  // R8: create is refused only when the pool was empty
  a_r8_create_err_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_err && trk_op == 2'd0) |-> ($past(free_mask) == '0));

  // R9: a refused request leaves the ownership state untouched
  a_r9_err_keeps_pool: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_err) |-> $stable(free_mask));

endmodule

bind seg_page_alloc spa_checker #(.NSEG(NSEG)) u_chk (
  .clk(clk), .rst_n(rst_s), .req_valid(req_valid), .req_op(req_op),
  .req_ready(req_ready), .gnt_valid(gnt_valid), .gnt_err(gnt_err),
  .free_mask(free_mask)
);

// File: tb/seg_page_alloc_bench.sv
module seg_page_alloc_bench;

  localparam int NV = 12;
  // {op[2], file[6], err[1], efile[6], epage[11], ewear[8]}
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 6'd0, 1'b0, 6'd0, 11'd0,  8'd0},  // R3 create -> seg 0
    {2'd0, 6'd0, 1'b0, 6'd1, 11'd32, 8'd0},  // R3 create -> seg 1
    {2'd1, 6'd0, 1'b0, 6'd0, 11'd0,  8'd0},  // R4 append f0
    {2'd1, 6'd0, 1'b0, 6'd0, 11'd1,  8'd0},  // R4 append f0
    {2'd1, 6'd1, 1'b0, 6'd1, 11'd32, 8'd0},  // R4 append f1
    {2'd2, 6'd0, 1'b0, 6'd2, 11'd64, 8'd0},  // R6 extend f0 -> seg 2
    {2'd1, 6'd0, 1'b0, 6'd0, 11'd64, 8'd0},  // R6 append goes to seg 2
    {2'd1, 6'd2, 1'b1, 6'd2, 11'd0,  8'd0},  // R9 seg 2 is not a head
    {2'd3, 6'd0, 1'b0, 6'd0, 11'd0,  8'd0},  // R7 free f0
    {2'd1, 6'd0, 1'b1, 6'd0, 11'd0,  8'd0},  // R9 freed handle
    {2'd0, 6'd0, 1'b0, 6'd0, 11'd0,  8'd0},  // R3 create reuses seg 0
    {2'd3, 6'd5, 1'b1, 6'd5, 11'd0,  8'd0}   // R9 free of unowned
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [5:0]  req_file = 6'd0;
  logic        req_ready, gnt_valid, gnt_err;
  logic [5:0]  gnt_file;
  logic [10:0] gnt_page;
  logic [7:0]  gnt_wear;

  int n_vec = 0;
  int n_bad = 0;
  logic        r_err;
  logic [5:0]  r_file;
  logic [10:0] r_page;
  logic [7:0]  r_wear;

  always #5 clk = ~clk;

  seg_page_alloc u_seg_page_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_file(req_file), .req_ready(req_ready), .gnt_valid(gnt_valid),
    .gnt_err(gnt_err), .gnt_file(gnt_file), .gnt_page(gnt_page),
    .gnt_wear(gnt_wear)
  );

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic apply(input logic [1:0] op, input logic [5:0] file);
    int t;
    @(negedge clk);
    t = 0;
    while (!req_ready && t < 100) begin @(negedge clk); t++; end
    req_op = op; req_file = file; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!gnt_valid && t < 100) begin @(negedge clk); t++; end
    if (!gnt_valid) begin
      n_bad++;
      $display("FAIL R1 no grant: actual gnt_valid=0 expected 1");
      r_err = 1'bx; r_file = 'x; r_page = 'x; r_wear = 'x;
    end else begin
      r_err = gnt_err; r_file = gnt_file; r_page = gnt_page; r_wear = gnt_wear;
      if (!req_ready) begin
        n_bad++;
        $display("FAIL R1 ready at grant: actual 0 expected 1");
      end
    end
  endtask

  task automatic check(input string tag, input logic e_err, input logic [5:0] e_file,
                       input logic [10:0] e_page, input logic [7:0] e_wear);
    n_vec++;
    if (r_err !== e_err || r_file !== e_file || r_page !== e_page || r_wear !== e_wear) begin
      n_bad++;
      $display("FAIL %s: actual err=%0d file=%0d page=%0d wear=%0d expected err=%0d file=%0d page=%0d wear=%0d",
               tag, r_err, r_file, r_page, r_wear, e_err, e_file, e_page, e_wear);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int bad_seq;
    do_reset();

    // R2: reset state at the ports
    n_vec++;
    if (req_ready !== 1'b1 || gnt_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R2 reset: actual ready=%0d gnt=%0d expected ready=1 gnt=0",
               req_ready, gnt_valid);
    end

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][33:32], VEC[i][31:26]);
      check($sformatf("R3/R4/R6/R7/R9 vector %0d", i), VEC[i][25], VEC[i][24:19],
            VEC[i][18:8], VEC[i][7:0]);
    end

    // R4/R5: f0 is seg 0 at offset 0; 32 appends in order, wrap bumps wear
    bad_seq = 0;
    for (int i = 0; i < 31; i++) begin
      apply(2'd1, 6'd0);
      if (r_err !== 1'b0 || r_page !== 11'(i) || r_wear !== 8'd0) bad_seq++;
    end
    n_vec++;
    if (bad_seq != 0) begin
      n_bad++;
      $display("FAIL R4 page order: actual %0d bad pages expected 0", bad_seq);
    end
    apply(2'd1, 6'd0);
    check("R5 wear on wrap", 1'b0, 6'd0, 11'd31, 8'd1);
    apply(2'd1, 6'd0);
    check("R4 offset wraps", 1'b0, 6'd0, 11'd0, 8'd1);

    // R7: free both files; counts are kept, so create skips worn seg 0
    apply(2'd3, 6'd0);
    check("R7 free f0", 1'b0, 6'd0, 11'd0, 8'd0);
    apply(2'd3, 6'd1);
    check("R7 free f1", 1'b0, 6'd1, 11'd0, 8'd0);
    apply(2'd0, 6'd0);
    check("R3 least worn over lowest index", 1'b0, 6'd1, 11'd32, 8'd0);

    // R3: drain the remaining zero-count segments in index order
    bad_seq = 0;
    for (int s = 2; s < 64; s++) begin
      apply(2'd0, 6'd0);
      if (r_err !== 1'b0 || r_file !== 6'(s) || r_page !== 11'(s * 32)) bad_seq++;
    end
    n_vec++;
    if (bad_seq != 0) begin
      n_bad++;
      $display("FAIL R3 index order: actual %0d bad grants expected 0", bad_seq);
    end
    apply(2'd0, 6'd0);
    check("R7 retained wear on reuse", 1'b0, 6'd0, 11'd0, 8'd1);

    // R8: pool empty
    apply(2'd0, 6'd0);
    check("R8 create when full", 1'b1, 6'd0, 11'd0, 8'd0);
    apply(2'd2, 6'd5);
    check("R8 extend when full", 1'b1, 6'd5, 11'd0, 8'd0);
    apply(2'd1, 6'd1);
    check("R8 table unchanged", 1'b0, 6'd1, 11'd32, 8'd0);
    apply(2'd3, 6'd10);
    check("R7 free f10", 1'b0, 6'd10, 11'd0, 8'd0);
    apply(2'd0, 6'd0);
    check("R3 refill seg 10", 1'b0, 6'd10, 11'd320, 8'd0);

    // R2: a second reset clears wear counts
    do_reset();
    apply(2'd0, 6'd0);
    check("R2 counts cleared", 1'b0, 6'd0, 11'd0, 8'd0);

    // R5: saturation after 255 wraps
    for (int i = 0; i < 255 * 32 - 1; i++) apply(2'd1, 6'd0);
    apply(2'd1, 6'd0);
    check("R5 reaches max", 1'b0, 6'd0, 11'd31, 8'd255);
    for (int i = 0; i < 31; i++) apply(2'd1, 6'd0);
    apply(2'd1, 6'd0);
    check("R5 saturates", 1'b0, 6'd0, 11'd31, 8'd255);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule